// File: doc/BRIEF.md
# Single-Error Repair Engine for a 512-Byte Flash Chunk

This block runs after a 512-byte chunk has been read from flash into a local byte buffer. It takes the three-byte check code that was stored with the chunk and the three-byte code recomputed over the data as it arrived. XORing the two gives a 24-bit syndrome, and the block classifies that syndrome. When the syndrome points at a single flipped data bit, the block reads the affected byte from the buffer, inverts that bit and writes the byte back. It then raises a one-cycle completion pulse and presents a result code.

The syndrome is made of twelve bit pairs. A single data error leaves every pair with two different bits, and the odd bit of each pair then carries one bit of the error location. Nine of these odd bits form the byte address and three form the bit number. A syndrome with exactly one bit set means the damage is in the stored code and the data is intact. A chunk that was never programmed stores all-ones as its code, and the block can be told to accept such a chunk as clean.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: After reset, `done`, `buf_rd_en` and `buf_wr_en` are low.
- R2: A zero syndrome (stored XOR computed) reports result 0 (clean) with no buffer access. `done` is high in the second cycle after the edge that samples `start`.
- R3: When `ignore_blank` is 1 and the stored code is 0xFFFFFF, the result is 0 (clean) whatever the syndrome, and the buffer is not accessed. When `ignore_blank` is 0, such a code is classified by the normal rules.
- R4: A syndrome in which every pair (bit 2p+1, bit 2p), p = 0..11, holds two different values is correctable. The block reads the indexed byte, writes it back on the next cycle with one bit inverted, and pulses `done` with result 1 (repaired) one cycle after the write.
- R5: The bit number of a repair is {syn[23], syn[21], syn[19]}, with syn[19] as the LSB.
- R6: The byte address of a repair is {syn[17], syn[15], ..., syn[3], syn[1]}, with syn[1] as the LSB. Stored byte k sits in bits [8k+7:8k] of the code ports.
- R7: A syndrome with exactly one bit set reports result 2 (code-only error), leaves the buffer unchanged, and `done` arrives on the same cycle as for R2.
- R8: Any other non-zero syndrome reports result 3 (uncorrectable) and leaves the buffer unchanged.
- R9: `done` is a single-cycle pulse. A `start` asserted while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check; sampled only when idle |
| ignore_blank | input | 1 | Treat an all-ones stored code as an unprogrammed chunk |
| ecc_stored | input | 24 | Code read back with the chunk (byte k in bits 8k+7:8k) |
| ecc_calc | input | 24 | Code recomputed over the data |
| buf_addr | output | 9 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe; data returns the next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 clean, 1 repaired, 2 code-only error, 3 uncorrectable |

## Verification
The main patterns are the 4096 single-bit data errors, one for every byte and bit position, each injected into a freshly randomised chunk. These separate a correct address and bit scatter from a swapped or shifted one, because any mistake flips the wrong bit in the buffer. Syndromes with one bit set are tried at all 24 positions to tell the code-only path apart from the repair path. Two-error syndromes show that the pair test rejects patterns that only look like a location. All-ones stored codes with and without the blank flag show that the flag controls the classification. A second `start` issued in the middle of a repair shows that requests arriving while the block is busy are dropped.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

   typedef enum logic [1:0] {
      FIX_CLEAN    = 2'd0,
      FIX_REPAIRED = 2'd1,
      FIX_ECC_ONLY = 2'd2,
      FIX_UNCORR   = 2'd3
   } fix_res_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_CLASS = 2'd1,
      SQ_READ  = 2'd2,
      SQ_WRITE = 2'd3
   } fix_state_t;

endpackage

// File: rtl/syn_classifier.sv
module syn_classifier #(
   parameter int ECC_W = 24
) (
   input  logic [ECC_W-1:0] syn,
   input  logic [ECC_W-1:0] stored,
   input  logic             blank_en,
   output logic             is_zero,
   output logic             is_blank,
   output logic             pair_ok,
   output logic             single_bit
);
   localparam int NPAIR = ECC_W / 2;
   localparam int CNT_W = $clog2(ECC_W + 1);

   logic [NPAIR-1:0] pair_diff;
   logic [CNT_W-1:0] ones;

   generate
      for (genvar p = 0; p < NPAIR; p++) begin : g_pair
         assign pair_diff[p] = syn[2*p+1] ^ syn[2*p];
      end
   endgenerate

   always_comb begin
      ones = '0;
      for (int i = 0; i < ECC_W; i++)
         ones = ones + CNT_W'(syn[i]);
   end

   assign is_zero    = (syn == '0);
   assign is_blank   = blank_en && (stored == {ECC_W{1'b1}});
   assign pair_ok    = &pair_diff;
   assign single_bit = (ones == CNT_W'(1));

endmodule

// File: rtl/err_locator.sv
module err_locator #(
   parameter int ADDR_W = 9,
   parameter int BYTE_W = 8
) (
   input  logic [ADDR_W+$clog2(BYTE_W)-1:0] loc,
   output logic [ADDR_W-1:0]                byte_idx,
   output logic [BYTE_W-1:0]                flip_mask
);
   localparam int BIT_W = $clog2(BYTE_W);

   logic [BIT_W-1:0] bit_idx;

   assign byte_idx = loc[ADDR_W-1:0];
   assign bit_idx  = loc[ADDR_W+BIT_W-1:ADDR_W];

   generate
      for (genvar g = 0; g < BYTE_W; g++) begin : g_dec
         assign flip_mask[g] = (bit_idx == BIT_W'(g));
      end
   endgenerate

endmodule

// File: rtl/fix_sequencer.sv
module fix_sequencer
   import ecc_fix_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     is_zero,
   input  logic     is_blank,
   input  logic     pair_ok,
   input  logic     single_bit,
   output logic     accept,
   output logic     rd_en,
   output logic     wr_en,
   output logic     done,
   output fix_res_t result
);
   fix_state_t state_q;
   logic       done_q;
   fix_res_t   res_q;

   assign accept = (state_q == SQ_IDLE) && start;
   assign rd_en  = (state_q == SQ_READ);
   assign wr_en  = (state_q == SQ_WRITE);
   assign done   = done_q;
   assign result = res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         done_q  <= 1'b0;
         res_q   <= FIX_CLEAN;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SQ_IDLE: if (start) state_q <= SQ_CLASS;
            SQ_CLASS: begin
               if (is_zero || is_blank) begin
                  res_q <= FIX_CLEAN;   done_q <= 1'b1; state_q <= SQ_IDLE;
               end else if (pair_ok) begin
                  state_q <= SQ_READ;
               end else if (single_bit) begin
                  res_q <= FIX_ECC_ONLY; done_q <= 1'b1; state_q <= SQ_IDLE;
               end else begin
                  res_q <= FIX_UNCORR;  done_q <= 1'b1; state_q <= SQ_IDLE;
               end
            end
            SQ_READ:  state_q <= SQ_WRITE;
            SQ_WRITE: begin
               res_q   <= FIX_REPAIRED;
               done_q  <= 1'b1;
               state_q <= SQ_IDLE;
            end
            default:  state_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
   import ecc_fix_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int BYTE_W    = 8,
   parameter int ECC_BYTES = 3,
   localparam int ECC_W    = ECC_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ignore_blank,
   input  logic [ECC_W-1:0]  ecc_stored,
   input  logic [ECC_W-1:0]  ecc_calc,
   output logic [ADDR_W-1:0] buf_addr,
   output logic              buf_rd_en,
   input  logic [BYTE_W-1:0] buf_rdata,
   output logic              buf_wr_en,
   output logic [BYTE_W-1:0] buf_wdata,
   output logic              done,
   output logic [1:0]        result
);
   localparam int BIT_W = $clog2(BYTE_W);
   localparam int NPAIR = ECC_W / 2;
   localparam int LOC_W = ADDR_W + BIT_W;

   generate
      if (NPAIR != LOC_W) begin : g_bad_geom
         $error("ecc_syndrome_fixer: syndrome pairs must equal address plus bit index width");
      end
      if ((1 << BIT_W) != BYTE_W) begin : g_bad_byte
         $error("ecc_syndrome_fixer: BYTE_W must be a power of two");
      end
   endgenerate

   logic [ECC_W-1:0]  syn_q, stored_q;
   logic              blank_q;
   logic              accept;
   logic              is_zero, is_blank, pair_ok, single_bit;
   logic [LOC_W-1:0]  loc;
   logic [BYTE_W-1:0] flip_mask;
   fix_res_t          res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syn_q    <= '0;
         stored_q <= '0;
         blank_q  <= 1'b0;
      end else if (accept) begin
         syn_q    <= ecc_stored ^ ecc_calc;
         stored_q <= ecc_stored;
         blank_q  <= ignore_blank;
      end
   end

   generate
      for (genvar p = 0; p < NPAIR; p++) begin : g_odd
         assign loc[p] = syn_q[2*p+1];
      end
   endgenerate

   syn_classifier #(.ECC_W(ECC_W)) cls_i (
      .syn        (syn_q),
      .stored     (stored_q),
      .blank_en   (blank_q),
      .is_zero    (is_zero),
      .is_blank   (is_blank),
      .pair_ok    (pair_ok),
      .single_bit (single_bit)
   );

   err_locator #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) loc_i (
      .loc       (loc),
      .byte_idx  (buf_addr),
      .flip_mask (flip_mask)
   );

   fix_sequencer seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .is_zero    (is_zero),
      .is_blank   (is_blank),
      .pair_ok    (pair_ok),
      .single_bit (single_bit),
      .accept     (accept),
      .rd_en      (buf_rd_en),
      .wr_en      (buf_wr_en),
      .done       (done),
      .result     (res)
   );

   assign buf_wdata = buf_rdata ^ flip_mask;
   assign result    = res;

endmodule

// File: rtl/ecc_fix_chk.sv
module ecc_fix_chk #(
   parameter int ADDR_W = 9,
   parameter int BYTE_W = 8,
   parameter int ECC_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic [1:0]        result,
   input logic              buf_rd_en,
   input logic              buf_wr_en,
   input logic [ADDR_W-1:0] buf_addr,
   input logic [BYTE_W-1:0] buf_rdata,
   input logic [BYTE_W-1:0] buf_wdata,
   input logic [ECC_W-1:0]  syn_q
);
   // R4
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd_en |=> buf_wr_en);
   // R4
   wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |=> (done && result == 2'd1));
   // R6
   same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> ($past(buf_rd_en) && buf_addr == $past(buf_addr)));
   // R5
   one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> $onehot(buf_wdata ^ buf_rdata));
   // R7
   ecc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == 2'd2) |-> $onehot(syn_q));
   // R8
   uncorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == 2'd3) |-> (syn_q != '0 && $countones(syn_q) != 1));
   // R9
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R1
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_rd_en && buf_wr_en));
endmodule

bind ecc_syndrome_fixer ecc_fix_chk #(
   .ADDR_W (ADDR_W),
   .BYTE_W (BYTE_W),
   .ECC_W  (ECC_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .done      (done),
   .result    (result),
   .buf_rd_en (buf_rd_en),
   .buf_wr_en (buf_wr_en),
   .buf_addr  (buf_addr),
   .buf_rdata (buf_rdata),
   .buf_wdata (buf_wdata),
   .syn_q     (syn_q)
);

// File: tb/ecc_syndrome_fixer_tb_top.sv
module ecc_syndrome_fixer_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ignore_blank = 1'b0;
   logic [23:0] ecc_stored = '0;
   logic [23:0] ecc_calc = '0;
   logic [8:0]  buf_addr;
   logic        buf_rd_en, buf_wr_en, done;
   logic [7:0]  buf_rdata = '0;
   logic [7:0]  buf_wdata;
   logic [1:0]  result;

   logic [7:0] mem     [512];
   logic [7:0] ref_mem [512];

   int total = 0;
   int bad   = 0;
   int due   = 0;
   int exp_res = 0;
   bit mon_on = 1'b0;
   string tag = "R2";

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_syndrome_fixer dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .ignore_blank (ignore_blank),
      .ecc_stored (ecc_stored), .ecc_calc (ecc_calc),
      .buf_addr (buf_addr), .buf_rd_en (buf_rd_en), .buf_rdata (buf_rdata),
      .buf_wr_en (buf_wr_en), .buf_wdata (buf_wdata),
      .done (done), .result (result)
   );

   always @(posedge clk) begin
      if (buf_rd_en) buf_rdata <= mem[buf_addr];
      if (buf_wr_en) mem[buf_addr] <= buf_wdata;
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // per-clock reference: done must appear exactly when predicted
   always @(negedge clk) begin
      if (mon_on) begin
         bit exp_done;
         exp_done = (due == 1);
         if (due > 0) due--;
         check(done == exp_done, tag, int'(done), int'(exp_done));
         if (exp_done)
            check(int'(result) == exp_res, tag, int'(result), exp_res);
      end
   end

   // model of the classification; returns code, fills byte and bit on repair
   function automatic int model(input logic [23:0] st, input logic [23:0] ca,
                                input bit blank, output int bidx, output int bit_n);
      logic [23:0] s;
      int cnt;
      bit pairs;
      s = st ^ ca;
      bidx = 0; bit_n = 0;
      if (s == 0) return 0;
      if (blank && st == 24'hFFFFFF) return 0;
      pairs = 1;
      for (int p = 0; p < 12; p++) if (s[2*p] == s[2*p+1]) pairs = 0;
      if (pairs) begin
         for (int p = 0; p < 9; p++) if (s[2*p+1]) bidx += (1 << p);
         for (int p = 9; p < 12; p++) if (s[2*p+1]) bit_n += (1 << (p-9));
         return 1;
      end
      cnt = 0;
      for (int i = 0; i < 24; i++) if (s[i]) cnt++;
      return (cnt == 1) ? 2 : 3;
   endfunction

   function automatic logic [23:0] err_syn(input int b, input int k);
      logic [23:0] s;
      for (int p = 0; p < 12; p++) begin
         bit v;
         v = (p < 9) ? b[p] : k[p-9];
         s[2*p+1] = v;
         s[2*p]   = ~v;
      end
      return s;
   endfunction

   task automatic refill();
      for (int i = 0; i < 512; i++) begin
         logic [7:0] v;
         v = 8'($urandom);
         mem[i] = v;
         ref_mem[i] = v;
      end
   endtask

   task automatic run(input logic [23:0] st, input logic [23:0] ca, input bit blank,
                      input string req, input bit collide);
      int code, bidx, bit_n, mism;
      code = model(st, ca, blank, bidx, bit_n);
      if (code == 1) ref_mem[bidx] = ref_mem[bidx] ^ 8'(1 << bit_n);
      @(posedge clk); #2;
      ecc_stored = st; ecc_calc = ca; ignore_blank = blank; start = 1'b1;
      tag = req; exp_res = code; due = (code == 1) ? 5 : 3;
      @(posedge clk); #2;
      start = 1'b0;
      if (collide) begin
         @(posedge clk); #2;
         ecc_stored = ~st; ecc_calc = 24'h0; start = 1'b1;
         @(posedge clk); #2;
         start = 1'b0;
      end
      while (due > 0) @(posedge clk);
      @(posedge clk); #2;
      mism = 0;
      for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) mism++;
      check(mism == 0, req, mism, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [23:0] c;
      refill();
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check(done == 1'b0 && buf_rd_en == 1'b0 && buf_wr_en == 1'b0, "R1",
            int'({done, buf_rd_en, buf_wr_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // R2 clean
      for (int n = 0; n < 4; n++) begin
         c = 24'($urandom);
         run(c, c, n[0], "R2", 1'b0);
      end
      // R3 blank chunk accepted / not accepted
      run(24'hFFFFFF, 24'h123456, 1'b1, "R3", 1'b0);
      run(24'hFFFFFF, 24'hFFFFFF ^ err_syn(7, 2), 1'b1, "R3", 1'b0);
      run(24'hFFFFFF, 24'hFFFFFF ^ 24'h000100, 1'b0, "R3", 1'b0);
      run(24'hFFFFFF, 24'hFFFFFF ^ err_syn(33, 6), 1'b0, "R3", 1'b0);
      // R7 single syndrome bit at every position
      for (int i = 0; i < 24; i++) begin
         c = 24'($urandom);
         run(c ^ (24'h1 << i), c, 1'b0, "R7", 1'b0);
      end
      // R8 double data errors
      for (int n = 0; n < 16; n++) begin
         int b1, b2;
         b1 = $urandom_range(0, 511);
         b2 = (b1 + 1 + $urandom_range(0, 509)) % 512;
         c = 24'($urandom);
         run(c ^ err_syn(b1, $urandom_range(0, 7)) ^ err_syn(b2, $urandom_range(0, 7)),
             c, 1'b0, "R8", 1'b0);
      end
      // R9 start during a repair is dropped
      c = 24'($urandom);
      run(c ^ err_syn(300, 5), c, 1'b0, "R9", 1'b1);
      // R4 R5 R6 every single data-bit error
      for (int b = 0; b < 512; b++) begin
         refill();
         for (int k = 0; k < 8; k++) begin
            c = 24'($urandom);
            run(c ^ err_syn(b, k), c, 1'b0, (k == 0) ? "R6" : "R4_R5", 1'b0);
         end
      end
      mon_on = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule